// File: doc/BRIEF.md
# Serial Shift Port

The block moves one byte at a time over a synchronous three-wire link made of a shift clock, a serial input and a serial output. Software sets a mode register with the bit order, the direction (full duplex, or receive only) and the clock source. It loads the data buffer and pulses a start strobe. The block then runs eight shift-clock periods. Each bit goes out on a falling edge of the shift clock, and each incoming bit is captured on the rising edge that follows. When the byte is done, the buffer holds the received byte and an interrupt request is raised.

The shift clock has three possible sources. The first is an internal divider of the system clock, with four rates. The second is a pulse train from a timer/counter, where each pulse marks one half period. The third is an external clock pin, which is synchronised into the system clock domain. With an external clock the block does not drive the clock pin, and it ignores any edge that arrives while no transfer is running.

The controller is a three-state machine. ST_IDLE waits for start; ST_HIGH holds the clock high until a falling edge event, which drives the next output bit (transition ST_HIGH to ST_LOW); ST_LOW holds the clock low until a rising edge event, which captures the input bit and returns to ST_HIGH, or to ST_IDLE after the eighth bit (transition ST_LOW to ST_IDLE, raising the interrupt).

Top module: `ser_shift_port`

## Requirements
- R1: After reset sck_out=1, sck_oe=1, so=1, ints=0 and buf_dout=0. The mode register resets to 0: internal clock, rate 0, full duplex, MSB first.
- R2: Start in idle clears ints. The transfer then ends after exactly 8 falling and 8 rising shift-clock edges. At the end ints is set and stays set until the next start, and sck_out and so return high.
- R3: With mode_din[5]=0 (MSB first), the bit on so at the k-th falling edge is tx bit 7-k. The received byte ends in the buffer with the first bit sampled at bit 7. so changes only when the shift clock falls or when the transfer ends.
- R4: With mode_din[5]=1 (LSB first), the bit on so at the k-th falling edge is tx bit k. The first bit sampled ends at bit 0.
- R5: With mode_din[4]=1 (receive only), so stays 1 for the whole transfer while the buffer still receives all 8 bits.
- R6: mode_din[3:2]=00 selects the internal clock. Each half period of sck_out then lasts 2^n system clocks, where n=mode_din[1:0].
- R7: mode_din[3:2]=01 selects the timer clock. Each tmr_tick pulse ends one half period of sck_out.
- R8: mode_din[3]=1 selects the external clock. sck_oe=0 and sck_out=1. so changes after a falling edge of sck_in, and si is captured on rising edges of sck_in.
- R9: After an external-clock transfer completes, further sck_in edges do not change the buffer, so or ints.
- R10: While a transfer runs, mode_wr, buf_wr and start have no effect. The byte sent, the byte received, the rate and the edge count stay those of the started transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_din | input | 6 | Mode value: [1:0] rate exponent, [3:2] clock source, [4] receive only, [5] LSB first |
| buf_wr | input | 1 | Data buffer write strobe |
| buf_din | input | DATA_W | Byte to load into the buffer |
| buf_dout | output | DATA_W | Current buffer contents |
| start | input | 1 | Begin a transfer (taken in idle only) |
| tmr_tick | input | 1 | Timer/counter half-period pulse |
| sck_in | input | 1 | External shift clock |
| si | input | 1 | Serial data in |
| sck_out | output | 1 | Shift clock driven out |
| sck_oe | output | 1 | Shift clock output enable |
| so | output | 1 | Serial data out |
| ints | output | 1 | Transfer-complete interrupt request |

## Verification
The inline assertions check several properties on every cycle. The lines sit high in ST_IDLE, and so stays high during receive-only transfers. The buffer and the mode register hold still whenever no capture edge occurs, so moves only on shift-clock events, and the last rising edge always lands in ST_IDLE with ints set. The divider count never passes its limit. Only the bench scenarios can show the bit order on the wire, the exact half-period length for every rate and for the timer source, the received byte, and the rejection of writes in mid-transfer and of stray external edges. The bench sweeps every rate against every order and direction combination.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    localparam int RATE_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } ssp_state_e;

    localparam logic [1:0] SRC_INT = 2'b00;
    localparam logic [1:0] SRC_TMR = 2'b01;

    typedef struct packed {
        logic              lsb_first;
        logic              rx_only;
        logic [1:0]        src;
        logic [RATE_W-1:0] rate;
    } ssp_mode_t;
endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen
    import ssp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [1:0]        src,
    input  logic [RATE_W-1:0] rate,
    input  logic              sck_lvl,
    input  logic              sck_in,
    input  logic              tmr_tick,
    output logic              fall_ev,
    output logic              rise_ev
);
    localparam int CNT_W = (1 << RATE_W) - 1;

    logic [CNT_W-1:0] div_cnt;
    logic [CNT_W-1:0] div_lim;
    logic [CNT_W-1:0] one_v;
    logic             div_done;
    logic             toggle;
    logic             is_ext;
    logic [2:0]       sync_q;
    logic             ext_rise;
    logic             ext_fall;

    assign one_v    = {{(CNT_W-1){1'b0}}, 1'b1};
    assign div_lim  = (one_v << rate) - one_v;
    assign div_done = run && (div_cnt == div_lim);
    assign is_ext   = src[1];
    assign toggle   = (src == SRC_TMR) ? tmr_tick : div_done;
    assign ext_rise = sync_q[1] && !sync_q[2];
    assign ext_fall = !sync_q[1] && sync_q[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            sync_q  <= 3'b111;
        end else begin
            sync_q <= {sync_q[1:0], sck_in};
            if (!run || div_done) div_cnt <= '0;
            else                  div_cnt <= div_cnt + one_v;
        end
    end

    always_comb begin
        fall_ev = 1'b0;
        rise_ev = 1'b0;
        if (run) begin
            if (is_ext) begin
                fall_ev = ext_fall;
                rise_ev = ext_rise;
            end else begin
                fall_ev = toggle && sck_lvl;
                rise_ev = toggle && !sck_lvl;
            end
        end
    end

    // R6: the divider never counts past the limit chosen by the rate field
    assert_div_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && src == SRC_INT) |-> (div_cnt <= div_lim));
endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
    import ssp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [$bits(ssp_mode_t)-1:0] mode_din,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_din,
    input  logic              start,
    input  logic              si,
    input  logic              fall_ev,
    input  logic              rise_ev,
    output logic              run,
    output logic              sck_q,
    output logic              so,
    output logic              ints,
    output logic [DATA_W-1:0] sreg,
    output ssp_mode_t         mode_q
);
    localparam int BC_W = $clog2(DATA_W);

    ssp_state_e state, nxt;
    logic [BC_W-1:0] bit_cnt;
    logic            last;
    logic            out_bit;

    assign run     = (state != ST_IDLE);
    assign last    = (bit_cnt == BC_W'(DATA_W - 1));
    assign out_bit = mode_q.lsb_first ? sreg[0] : sreg[DATA_W-1];

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start)   nxt = ST_HIGH;
            ST_HIGH: if (fall_ev) nxt = ST_LOW;
            ST_LOW:  if (rise_ev) nxt = last ? ST_IDLE : ST_HIGH;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            sreg    <= '0;
            bit_cnt <= '0;
            sck_q   <= 1'b1;
            so      <= 1'b1;
            ints    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    sck_q <= 1'b1;
                    so    <= 1'b1;
                    if (mode_wr) mode_q <= ssp_mode_t'(mode_din);
                    if (buf_wr)  sreg   <= buf_din;
                    if (start) begin
                        bit_cnt <= '0;
                        ints    <= 1'b0;
                    end
                end
                ST_HIGH: begin
                    if (fall_ev) begin
                        sck_q <= 1'b0;
                        so    <= mode_q.rx_only ? 1'b1 : out_bit;
                    end
                end
                ST_LOW: begin
                    if (rise_ev) begin
                        sck_q   <= 1'b1;
                        bit_cnt <= bit_cnt + 1'b1;
                        if (mode_q.lsb_first) sreg <= {si, sreg[DATA_W-1:1]};
                        else                  sreg <= {sreg[DATA_W-2:0], si};
                        if (last) begin
                            ints <= 1'b1;
                            so   <= 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R2: idle lines rest high
    assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (sck_q && so));
    // R2: the last capture edge ends the transfer with the request raised
    assert_end_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOW && rise_ev && last) |=> (state == ST_IDLE && ints));
    // R5: receive-only keeps the output line high
    assert_rx_only_so_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode_q.rx_only) |-> so);
    // R3: output moves only on shift-clock events
    assert_so_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !fall_ev && !rise_ev) |=> $stable(so));
    // R10: buffer only changes on a capture edge while running
    assert_buf_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !(state == ST_LOW && rise_ev)) |=> $stable(sreg));
    // R10: mode is frozen while running
    assert_mode_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> $stable(mode_q));
endmodule

// File: rtl/ser_shift_port.sv
module ser_shift_port
    import ssp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [5:0]        mode_din,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_din,
    output logic [DATA_W-1:0] buf_dout,
    input  logic              start,
    input  logic              tmr_tick,
    input  logic              sck_in,
    input  logic              si,
    output logic              sck_out,
    output logic              sck_oe,
    output logic              so,
    output logic              ints
);
    logic      run;
    logic      sck_q;
    logic      fall_ev;
    logic      rise_ev;
    ssp_mode_t mode_q;

    ssp_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_wr  (mode_wr),
        .mode_din (mode_din),
        .buf_wr   (buf_wr),
        .buf_din  (buf_din),
        .start    (start),
        .si       (si),
        .fall_ev  (fall_ev),
        .rise_ev  (rise_ev),
        .run      (run),
        .sck_q    (sck_q),
        .so       (so),
        .ints     (ints),
        .sreg     (buf_dout),
        .mode_q   (mode_q)
    );

    ssp_clkgen u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .src      (mode_q.src),
        .rate     (mode_q.rate),
        .sck_lvl  (sck_q),
        .sck_in   (sck_in),
        .tmr_tick (tmr_tick),
        .fall_ev  (fall_ev),
        .rise_ev  (rise_ev)
    );

    assign sck_oe  = !mode_q.src[1];
    assign sck_out = sck_oe ? sck_q : 1'b1;

    // R8: an external clock source never has the pin driven
    assert_ext_no_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q.src[1] |-> (!sck_oe && sck_out));
endmodule

// File: tb/ser_shift_port_bench.sv
module ser_shift_port_bench;
    localparam int CLK_T = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_wr = 1'b0;
    logic [5:0] mode_din = '0;
    logic       buf_wr = 1'b0;
    logic [7:0] buf_din = '0;
    logic [7:0] buf_dout;
    logic       start = 1'b0;
    logic       tmr_tick = 1'b0;
    logic       sck_in = 1'b1;
    logic       si = 1'b0;
    logic       sck_out, sck_oe, so, ints;

    int  total = 0;
    int  bad = 0;
    bit  done = 0;
    bit  tmr_en = 0;
    int  tmr_k = 2;

    ser_shift_port u_ser_shift_port (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_din(mode_din),
        .buf_wr(buf_wr), .buf_din(buf_din), .buf_dout(buf_dout), .start(start),
        .tmr_tick(tmr_tick), .sck_in(sck_in), .si(si), .sck_out(sck_out),
        .sck_oe(sck_oe), .so(so), .ints(ints)
    );

    always #(CLK_T/2) clk = ~clk;

    initial begin : tmr_gen
        int tcnt;
        tcnt = 0;
        forever begin
            @(negedge clk);
            if (tmr_en) begin
                tcnt++;
                if (tcnt >= tmr_k) begin tmr_tick = 1'b1; tcnt = 0; end
                else tmr_tick = 1'b0;
            end else begin
                tmr_tick = 1'b0;
                tcnt = 0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_mode(input logic [1:0] src, input logic [1:0] rate,
                              input bit rxo, input bit lsb);
        @(negedge clk);
        mode_din = {lsb, rxo, src, rate};
        mode_wr = 1'b1;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic load_and_start(input logic [7:0] tx);
        @(negedge clk);
        buf_din = tx;
        buf_wr = 1'b1;
        @(negedge clk);
        buf_wr = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(ints == 1'b0, "R2 ints cleared by start", ints, 0);
    endtask

    task automatic run_clocked(input logic [7:0] tx, input logic [7:0] rx, input bit rxo,
                               input bit lsb, input int exp_half, input bit disturb,
                               input string req);
        logic [7:0] got;
        logic       prev;
        int nfall, since_t, toggles, bad_half, guard;
        bit poke;
        got = '0; nfall = 0; since_t = 0; toggles = 0; bad_half = 0; guard = 0; poke = 0;
        load_and_start(tx);
        prev = sck_out;
        while (!ints && guard < 5000) begin
            @(negedge clk);
            guard++;
            since_t++;
            if (poke) begin
                buf_wr = 1'b0; mode_wr = 1'b0; start = 1'b0; poke = 0;
            end
            if (sck_out !== prev) begin
                if (toggles > 0 && since_t != exp_half) bad_half++;
                toggles++;
                since_t = 0;
                if (!sck_out) begin
                    int idx;
                    idx = lsb ? nfall : 7 - nfall;
                    got[idx] = so;
                    si = rx[idx];
                    nfall++;
                    if (disturb && nfall == 2) begin
                        buf_din = ~tx; buf_wr = 1'b1;
                        mode_din = 6'b0; mode_wr = 1'b1;
                        start = 1'b1; poke = 1;
                    end
                end
                prev = sck_out;
            end
        end
        check(ints == 1'b1, {req, " R2 ints set at end"}, ints, 1);
        check(nfall == 8, {req, " R2 eight falling edges"}, nfall, 8);
        check(got == (rxo ? 8'hFF : tx), {req, " bits on so"}, got, rxo ? 8'hFF : tx);
        check(buf_dout == rx, {req, " received byte"}, buf_dout, rx);
        check(bad_half == 0, {req, " half period length"}, bad_half, 0);
        check(sck_out && so, "R2 lines high after transfer", {sck_out, so}, 3);
    endtask

    task automatic run_ext(input logic [7:0] tx, input logic [7:0] rx, input bit rxo,
                           input bit lsb, input string req);
        logic [7:0] got;
        logic [7:0] snap;
        bit so_stray;
        got = '0;
        write_mode(2'b10, 2'b00, rxo, lsb);
        load_and_start(tx);
        check(!sck_oe && sck_out, "R8 clock pin not driven", {sck_oe, sck_out}, 1);
        for (int k = 0; k < 8; k++) begin
            int idx;
            idx = lsb ? k : 7 - k;
            si = rx[idx];
            sck_in = 1'b0;
            repeat (6) @(negedge clk);
            got[idx] = so;
            sck_in = 1'b1;
            repeat (6) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        check(ints == 1'b1, {req, " R8 ints at end"}, ints, 1);
        check(got == (rxo ? 8'hFF : tx), {req, " R8 bits on so"}, got, rxo ? 8'hFF : tx);
        check(buf_dout == rx, {req, " R8 received byte"}, buf_dout, rx);
        snap = buf_dout;
        so_stray = 0;
        for (int k = 0; k < 3; k++) begin
            si = ~si;
            sck_in = 1'b0;
            repeat (6) @(negedge clk);
            if (!so) so_stray = 1;
            sck_in = 1'b1;
            repeat (6) @(negedge clk);
        end
        check(buf_dout == snap, "R9 buffer unchanged by stray edges", buf_dout, snap);
        check(!so_stray && so, "R9 so stays high", so_stray, 0);
        check(ints == 1'b1, "R9 ints stays set", ints, 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(sck_out == 1'b1, "R1 sck_out", sck_out, 1);
        check(sck_oe == 1'b1, "R1 sck_oe", sck_oe, 1);
        check(so == 1'b1, "R1 so", so, 1);
        check(ints == 1'b0, "R1 ints", ints, 0);
        check(buf_dout == 8'h00, "R1 buffer", buf_dout, 0);

        for (int rate = 0; rate < 4; rate++) begin
            for (int m = 0; m < 4; m++) begin
                logic [7:0] tx, rx;
                string req;
                tx = 8'hA5 ^ 8'(rate * 37 + m * 11);
                rx = 8'h3C + 8'(rate * 16 + m * 3);
                req = m[1] ? "R4 R6" : "R3 R6";
                if (m[0]) req = {req, " R5"};
                write_mode(2'b00, 2'(rate), m[0], m[1]);
                run_clocked(tx, rx, m[0], m[1], 1 << rate, 1'b0, req);
            end
        end

        tmr_en = 1;
        for (int j = 0; j < 3; j++) begin
            tmr_k = (j == 0) ? 2 : (j == 1) ? 3 : 5;
            write_mode(2'b01, 2'b00, 1'b0, j[0]);
            run_clocked(8'h5A + 8'(j), 8'hC3 - 8'(j * 7), 1'b0, j[0], tmr_k, 1'b0, "R7");
        end
        tmr_en = 0;

        write_mode(2'b00, 2'b10, 1'b0, 1'b0);
        run_clocked(8'h96, 8'h2D, 1'b0, 1'b0, 4, 1'b1, "R10");

        run_ext(8'hB1, 8'h4E, 1'b0, 1'b0, "R3");
        run_ext(8'h1D, 8'hE7, 1'b0, 1'b1, "R4");
        run_ext(8'h77, 8'h81, 1'b1, 1'b0, "R5");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule